// File: doc/BRIEF.md
# XOR Parity Cell Reassembler

This block sits behind a cell switch fabric. Each packet reaches it as a group of fixed-length data cells plus one parity cell, and the parity cell is the bitwise XOR of the packet's data cells. The fabric can lose cells, and it can deliver the cells of one packet in any order. The block collects the cells of one packet at a time. It stores each data cell by its index and folds every payload word it receives, data or parity, into a one-cell XOR accumulator.

A packet is closed in one of two ways: a header carrying a different packet identifier is presented, or the input stays idle for a set number of cycles. When the packet closes, the block decides what to do with it:

- If every data cell arrived, the block sends the packet out as it is.
- If exactly one data cell is missing and the parity cell arrived, the accumulator already holds the missing cell, and the block substitutes it.
- In every other case the block discards the packet and increments a drop counter.

Surviving packets leave in ascending cell-index order, and the parity cell is never sent out. Both stream edges use valid/ready. A beat transfers on a clock edge where valid and ready are both high. The source must hold its valid, tag and data until the beat transfers. The block holds `out_valid`, `out_tag` and `out_data` steady while `out_ready` is low. It takes no input while it is emitting, while it is judging a packet, or while a header of the next packet is waiting for the current packet to close.

Top module: `xrr_reassembler`

## Requirements
- R1: Input cell framing:
  - A cell is one header word tagged 2'b11, followed by WORDS payload words. Each payload word is tagged 2'b00 except the last, which is tagged 2'b10.
  - The header bits are: bit 18 is the parity flag, bits 17:13 are the packet's data-cell count, bits 12:7 are the cell index, and bits 6:0 are the packet identifier.
- R2: A packet whose data cells all arrived is emitted unchanged, one cell per index, in ascending index order. This holds whether or not its parity cell arrived. The parity cell is never forwarded.
- R3: When exactly one data cell of a packet is missing and its parity cell arrived, the missing cell is emitted in its place. Its payload is the XOR of all received payload words at the same word position.
- R4: The packet is emitted nothing and `drop_count` increases by exactly one when any of these holds:
  - two or more data cells are missing;
  - one data cell is missing and no parity cell arrived;
  - the count is 0;
  - the count exceeds MAXC.
- R5: While a packet is open, a presented header whose identifier differs closes that packet. That header is refused (`in_ready` low) until the closed packet has been emitted or dropped, and it is then accepted as the first cell of a new packet.
- R6: An open packet is closed after TMO_CYC consecutive cycles with no accepted beat. For a packet that is emitted, `out_valid` first rises TMO_CYC+2 clock edges after the edge that accepted its last beat.
- R7: Each emitted cell is one header word followed by WORDS payload words:
  - The header word is tagged 2'b11. Its bits 63:19 are zero and its parity flag is 0, and it carries the count, the index and the packet identifier.
  - The payload words are tagged 2'b00, except the last, which is tagged 2'b10.
- R8: While `out_valid` is high and `out_ready` is low, the output word and tag hold steady. `in_ready` is low whenever `out_valid` is high.
- R9: After reset, `out_valid` is 0, `drop_count` is 0 and `in_ready` is 1.
- R10: The accumulator is cleared when a new packet starts, so a recovered cell depends only on the cells of its own packet.
- R11: The cells of a packet, including the parity cell, may arrive in any order without changing the emitted result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block accepts the input word |
| in_tag | input | 2 | Framing tag of the input word |
| in_data | input | 64 | Input word |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Sink accepts the output word |
| out_tag | output | 2 | Framing tag of the output word |
| out_data | output | 64 | Output word |
| drop_count | output | DCW | Count of discarded packets, wrapping |

## Verification
The bench builds the block with the following parameters:

- WORDS=4, so each cell is a few beats long and many packets fit in a short run.
- MAXC=8, so a count of 9 can be sent to reach the oversize drop case.
- TMO_CYC=40, so the exact cycle on which the timeout closes a packet can be measured.
- DCW=8.

Random packets mix shuffled cell order, parity present or absent, zero to two lost data cells and random output back-pressure. Directed cases cover a packet closed by a newer identifier, a zero-count packet and back-to-back recoveries.

// File: rtl/xrr_pkg.sv
`timescale 1ns/1ps
package xrr_pkg;
  localparam int DW = 64;
  localparam logic [1:0] TAG_BODY = 2'b00;
  localparam logic [1:0] TAG_LAST = 2'b10;
  localparam logic [1:0] TAG_HEAD = 2'b11;

  // Header fields in the low bits of the header word (parity flag at bit 18).
  typedef struct packed {
    logic       coded;
    logic [4:0] count;
    logic [5:0] idx;
    logic [6:0] pid;
  } hdr_t;

  localparam int HW = $bits(hdr_t);

  typedef enum logic [1:0] {ST_GATHER, ST_JUDGE, ST_EMIT} st_e;
  typedef enum logic [1:0] {V_PASS, V_FIX, V_DROP} verdict_e;

  function automatic hdr_t hdr_of(input logic [DW-1:0] w);
    return hdr_t'(w[HW-1:0]);
  endfunction

  function automatic logic [DW-1:0] word_of(input hdr_t h);
    return {{(DW-HW){1'b0}}, h};
  endfunction
endpackage

// File: rtl/xrr_parse.sv
`timescale 1ns/1ps
module xrr_parse
  import xrr_pkg::*;
#(
  parameter int WORDS = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     beat,
  input  logic [1:0]               tag,
  input  logic [DW-1:0]            data,
  output logic                     hdr_fire,
  output logic                     pay_fire,
  output logic                     pay_end,
  output logic [5:0]               cell_idx,
  output logic                     cell_coded,
  output logic [$clog2(WORDS):0]   word_idx
);
  localparam int WIW = $clog2(WORDS) + 1;
  localparam logic [WIW-1:0] WSAT = WIW'(WORDS);

  logic in_cell_q;
  hdr_t h;

  assign h        = hdr_of(data);
  assign hdr_fire = beat && (tag == TAG_HEAD);
  assign pay_fire = beat && (tag != TAG_HEAD) && in_cell_q;
  assign pay_end  = pay_fire && (tag == TAG_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_cell_q  <= 1'b0;
      cell_idx   <= '0;
      cell_coded <= 1'b0;
      word_idx   <= '0;
    end else if (hdr_fire) begin
      in_cell_q  <= 1'b1;
      cell_idx   <= h.idx;
      cell_coded <= h.coded;
      word_idx   <= '0;
    end else if (pay_fire) begin
      if (word_idx != WSAT) word_idx <= word_idx + 1'b1;
      if (pay_end) in_cell_q <= 1'b0;
    end
  end
endmodule

// File: rtl/xrr_store.sv
`timescale 1ns/1ps
module xrr_store
  import xrr_pkg::*;
#(
  parameter int WORDS = 16,
  parameter int MAXC  = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr,
  input  logic                      we,
  input  logic                      done,
  input  logic                      cell_ok,
  input  logic                      coded,
  input  logic [$clog2(MAXC)-1:0]   cell_sel,
  input  logic [$clog2(WORDS):0]    wsel,
  input  logic [DW-1:0]             wdata,
  input  logic [$clog2(MAXC)-1:0]   rd_cell,
  input  logic [$clog2(WORDS)-1:0]  rd_word,
  output logic [DW-1:0]             rd_data,
  output logic [DW-1:0]             acc_data,
  output logic [MAXC-1:0]           present,
  output logic                      parity_seen
);
  localparam int WLW = $clog2(WORDS);
  localparam int WIW = WLW + 1;

  logic          win;
  logic [DW-1:0] mem   [MAXC][WORDS];
  logic [DW-1:0] acc_w [WORDS];

  assign win = wsel < WIW'(WORDS);

  // Data cells only; the parity cell lives solely in the accumulator.
  always_ff @(posedge clk) begin
    if (we && win && !coded && cell_ok) mem[cell_sel][wsel[WLW-1:0]] <= wdata;
  end

  // One XOR lane per word position, cleared at packet start.
  for (genvar g = 0; g < WORDS; g++) begin : g_acc
    logic [DW-1:0] a_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                          a_q <= '0;
      else if (clr)                                        a_q <= '0;
      else if (we && win && (wsel[WLW-1:0] == WLW'(g)))    a_q <= a_q ^ wdata;
    end
    assign acc_w[g] = a_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      present     <= '0;
      parity_seen <= 1'b0;
    end else if (clr) begin
      present     <= '0;
      parity_seen <= 1'b0;
    end else if (done) begin
      if (coded)        parity_seen       <= 1'b1;
      else if (cell_ok) present[cell_sel] <= 1'b1;
    end
  end

  assign rd_data  = mem[rd_cell][rd_word];
  assign acc_data = acc_w[rd_word];
endmodule

// File: rtl/xrr_judge.sv
`timescale 1ns/1ps
module xrr_judge
  import xrr_pkg::*;
#(
  parameter int MAXC = 16
) (
  input  logic [MAXC-1:0]         present,
  input  logic                    parity_seen,
  input  logic [4:0]              count,
  output verdict_e                verdict,
  output logic [$clog2(MAXC)-1:0] miss_idx
);
  localparam int CIW = $clog2(MAXC);

  logic [31:0] have;
  logic [1:0]  nmiss;
  logic [4:0]  mi;

  always_comb begin
    have  = 32'(present);
    nmiss = 2'd0;
    mi    = 5'd0;
    for (int i = 0; i < 32; i++) begin
      if ((i < int'(count)) && !have[i]) begin
        if (nmiss == 2'd0) mi = 5'(i);
        if (nmiss != 2'd2) nmiss = nmiss + 2'd1;
      end
    end
    if ((count == 5'd0) || (int'(count) > MAXC)) verdict = V_DROP;
    else if (nmiss == 2'd0)                      verdict = V_PASS;
    else if ((nmiss == 2'd1) && parity_seen)     verdict = V_FIX;
    else                                         verdict = V_DROP;
  end

  assign miss_idx = mi[CIW-1:0];
endmodule

// File: rtl/xrr_reassembler.sv
`timescale 1ns/1ps
module xrr_reassembler
  import xrr_pkg::*;
#(
  parameter int WORDS   = 16,
  parameter int MAXC    = 16,
  parameter int TMO_CYC = 1024,
  parameter int DCW     = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [1:0]     in_tag,
  input  logic [63:0]    in_data,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [1:0]     out_tag,
  output logic [63:0]    out_data,
  output logic [DCW-1:0] drop_count
);
  localparam int CIW = $clog2(MAXC);
  localparam int WLW = $clog2(WORDS);
  localparam int WIW = WLW + 1;
  localparam int TW  = $clog2(TMO_CYC + 1);
  localparam logic [WIW-1:0] WLAST = WIW'(WORDS);

  st_e            st_q;
  logic           active_q, fix_q;
  logic [6:0]     pid_q;
  logic [4:0]     count_q;
  logic [TW-1:0]  tcnt_q;
  logic [CIW-1:0] ci_q;
  logic [WIW-1:0] w_q;
  logic [DCW-1:0] drop_q;

  hdr_t     in_hdr, out_hdr;
  logic     conflict, tmo_hit, beat, start, last_cell;
  logic     hdr_fire, pay_fire, pay_end, cell_coded, cell_ok;
  logic [5:0]     cell_idx;
  logic [WIW-1:0] word_idx, wm1;
  logic [DW-1:0]  rd_data, acc_data;
  logic [MAXC-1:0] present;
  logic           parity_seen;
  verdict_e       verdict;
  logic [CIW-1:0] miss_idx;

  assign in_hdr   = hdr_of(in_data);
  assign conflict = active_q && in_valid && (in_tag == TAG_HEAD) && (in_hdr.pid != pid_q);
  assign tmo_hit  = active_q && (tcnt_q == TW'(TMO_CYC));
  assign in_ready = (st_q == ST_GATHER) && !conflict && !tmo_hit;
  assign beat     = in_valid && in_ready;
  assign start    = hdr_fire && !active_q;
  assign cell_ok  = int'(cell_idx) < MAXC;

  xrr_parse #(.WORDS(WORDS)) u_parse (
    .clk(clk), .rst_n(rst_n), .beat(beat), .tag(in_tag), .data(in_data),
    .hdr_fire(hdr_fire), .pay_fire(pay_fire), .pay_end(pay_end),
    .cell_idx(cell_idx), .cell_coded(cell_coded), .word_idx(word_idx)
  );

  assign wm1 = w_q - 1'b1;

  xrr_store #(.WORDS(WORDS), .MAXC(MAXC)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(start), .we(pay_fire && active_q),
    .done(pay_end && active_q), .cell_ok(cell_ok), .coded(cell_coded),
    .cell_sel(cell_idx[CIW-1:0]), .wsel(word_idx), .wdata(in_data),
    .rd_cell(ci_q), .rd_word(wm1[WLW-1:0]), .rd_data(rd_data),
    .acc_data(acc_data), .present(present), .parity_seen(parity_seen)
  );

  xrr_judge #(.MAXC(MAXC)) u_judge (
    .present(present), .parity_seen(parity_seen), .count(count_q),
    .verdict(verdict), .miss_idx(miss_idx)
  );

  assign last_cell = 5'(ci_q) == (count_q - 5'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_GATHER;
      active_q <= 1'b0;
      fix_q    <= 1'b0;
      pid_q    <= '0;
      count_q  <= '0;
      ci_q     <= '0;
      w_q      <= '0;
      drop_q   <= '0;
    end else begin
      case (st_q)
        ST_GATHER: begin
          if (start) begin
            active_q <= 1'b1;
            pid_q    <= in_hdr.pid;
            count_q  <= in_hdr.count;
          end
          if (conflict || tmo_hit) st_q <= ST_JUDGE;
        end
        ST_JUDGE: begin
          if (verdict == V_DROP) begin
            drop_q   <= drop_q + 1'b1;
            active_q <= 1'b0;
            st_q     <= ST_GATHER;
          end else begin
            fix_q <= (verdict == V_FIX);
            ci_q  <= '0;
            w_q   <= '0;
            st_q  <= ST_EMIT;
          end
        end
        ST_EMIT: begin
          if (out_ready) begin
            if (w_q == WLAST) begin
              w_q <= '0;
              if (last_cell) begin
                active_q <= 1'b0;
                st_q     <= ST_GATHER;
              end else begin
                ci_q <= ci_q + 1'b1;
              end
            end else begin
              w_q <= w_q + 1'b1;
            end
          end
        end
        default: st_q <= ST_GATHER;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   tcnt_q <= '0;
    else if (!active_q || beat)                   tcnt_q <= '0;
    else if ((st_q == ST_GATHER) && !tmo_hit)     tcnt_q <= tcnt_q + 1'b1;
  end

  always_comb begin
    out_hdr.coded = 1'b0;
    out_hdr.count = count_q;
    out_hdr.idx   = 6'(ci_q);
    out_hdr.pid   = pid_q;
  end

  assign out_valid  = (st_q == ST_EMIT);
  assign out_tag    = (w_q == '0) ? TAG_HEAD : ((w_q == WLAST) ? TAG_LAST : TAG_BODY);
  assign out_data   = (w_q == '0) ? word_of(out_hdr)
                    : ((fix_q && (ci_q == miss_idx)) ? acc_data : rd_data);
  assign drop_count = drop_q;
endmodule

// File: rtl/xrr_reassembler_chk.sv
`timescale 1ns/1ps
module xrr_reassembler_chk #(
  parameter int DCW = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           in_ready,
  input logic [1:0]     in_tag,
  input logic [63:0]    in_data,
  input logic           out_valid,
  input logic           out_ready,
  input logic [1:0]     out_tag,
  input logic [63:0]    out_data,
  input logic [DCW-1:0] drop_count
);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_tag));

  p_no_intake_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  p_drop_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (drop_count == $past(drop_count)) ||
             (drop_count == ($past(drop_count) + 1'b1)));

  p_tag_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_tag != 2'b01);

  p_head_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && (out_tag == 2'b10) |=> !out_valid || (out_tag == 2'b11));

  p_head_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_tag == 2'b11) |-> (out_data[63:18] == '0));
endmodule

bind xrr_reassembler xrr_reassembler_chk #(.DCW(DCW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_tag(in_tag), .in_data(in_data), .out_valid(out_valid),
  .out_ready(out_ready), .out_tag(out_tag), .out_data(out_data),
  .drop_count(drop_count)
);

// File: tb/xrr_reassembler_test.sv
`timescale 1ns/1ps
module xrr_reassembler_test;
  localparam int WORDS = 4;
  localparam int MAXC  = 8;
  localparam int TMO   = 40;
  localparam int DCW   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic           in_valid = 1'b0;
  logic           in_ready;
  logic [1:0]     in_tag = 2'b00;
  logic [63:0]    in_data = '0;
  logic           out_valid;
  logic           out_ready = 1'b1;
  logic [1:0]     out_tag;
  logic [63:0]    out_data;
  logic [DCW-1:0] drop_count;

  xrr_reassembler #(.WORDS(WORDS), .MAXC(MAXC), .TMO_CYC(TMO), .DCW(DCW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_tag(in_tag), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_tag(out_tag), .out_data(out_data),
    .drop_count(drop_count)
  );

  int n_chk = 0, n_fail = 0;
  int exp_n = 0, cap_n = 0, exp_drop = 0, viol = 0;
  bit rdy_rand = 1'b0;
  logic [65:0] expq [0:1023];
  logic [65:0] capq [0:1023];
  logic [63:0] pd   [0:15][0:WORDS-1];
  logic [63:0] par  [0:WORDS-1];

  task automatic check(input string req, input logic [65:0] act, input logic [65:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // Output side: choose ready at the falling edge, then record a beat that will transfer.
  always @(negedge clk) begin
    out_ready = rdy_rand ? (($urandom % 4) != 0) : 1'b1;
    if (rst_n && out_valid && out_ready) begin
      if (cap_n < 1024) capq[cap_n] = {out_tag, out_data};
      cap_n++;
    end
    if (rst_n && out_valid && in_ready) viol++;
  end

  task automatic put(input logic [1:0] t, input logic [63:0] d);
    in_valid = 1'b1; in_tag = t; in_data = d;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic logic [63:0] hword(input int pid, input int cnt, input int idx, input bit c);
    return {45'b0, c, 5'(cnt), 6'(idx), 7'(pid)};
  endfunction

  task automatic send_cell(input int pid, input int cnt, input int idx, input bit is_par);
    put(2'b11, hword(pid, cnt, idx, is_par));
    for (int w = 0; w < WORDS; w++)
      put((w == WORDS-1) ? 2'b10 : 2'b00, is_par ? par[w] : pd[idx][w]);
  endtask

  task automatic send_pkt(input int pid, input int cnt, input int omit, input bit with_par,
                          input bit shuf, input bit wait_done);
    int ord [0:16];
    int nm;
    bit ok;
    for (int w = 0; w < WORDS; w++) par[w] = '0;
    for (int c = 0; c < cnt; c++)
      for (int w = 0; w < WORDS; w++) begin
        pd[c][w] = {$urandom, $urandom};
        par[w]   = par[w] ^ pd[c][w];
      end
    for (int k = 0; k <= cnt; k++) ord[k] = k;
    if (shuf)
      for (int k = cnt; k > 0; k--) begin
        int j = int'($urandom % (k + 1));
        int t = ord[k];
        ord[k] = ord[j]; ord[j] = t;
      end
    for (int k = 0; k <= cnt; k++) begin
      if (ord[k] == cnt) begin
        if (with_par) send_cell(pid, cnt, cnt, 1'b1);
      end else if (!omit[ord[k]]) begin
        send_cell(pid, cnt, ord[k], 1'b0);
      end
    end
    nm = 0;
    for (int c = 0; c < cnt; c++) if (omit[c]) nm++;
    ok = (cnt >= 1) && (cnt <= MAXC) && ((nm == 0) || ((nm == 1) && with_par));
    if (ok) begin
      for (int c = 0; c < cnt; c++) begin
        expq[exp_n] = {2'b11, hword(pid, cnt, c, 1'b0)}; exp_n++;
        for (int w = 0; w < WORDS; w++) begin
          expq[exp_n] = {((w == WORDS-1) ? 2'b10 : 2'b00), pd[c][w]}; exp_n++;
        end
      end
    end else begin
      exp_drop++;
    end
    if (wait_done) repeat (TMO + 200) @(negedge clk);
  endtask

  task automatic compare(input string req);
    check(req, 66'(cap_n), 66'(exp_n));
    for (int i = 0; i < exp_n && i < cap_n; i++) check(req, capq[i], expq[i]);
    check(req, 66'(drop_count), 66'(exp_drop[DCW-1:0]));
    cap_n = 0; exp_n = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    report();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check("R9 out_valid", 66'(out_valid), 66'(0));
    check("R9 drop_count", 66'(drop_count), 66'(0));
    check("R9 in_ready", 66'(in_ready), 66'(1));

    // R2 and R7: complete packet in order, parity present
    send_pkt(3, 3, 0, 1'b1, 1'b0, 1'b1);
    compare("R2/R7 complete packet");
    // R2 and R11: parity absent, shuffled arrival
    send_pkt(4, 4, 0, 1'b0, 1'b1, 1'b1);
    compare("R2/R11 parity absent shuffled");
    // R3: one data cell lost, parity present
    send_pkt(5, 5, 32'h4, 1'b1, 1'b0, 1'b1);
    compare("R3 rebuild index 2");
    // R10: consecutive recoveries, back-pressure on
    rdy_rand = 1'b1;
    send_pkt(6, 4, 32'h1, 1'b1, 1'b0, 1'b1);
    send_pkt(7, 6, 32'h20, 1'b1, 1'b1, 1'b1);
    compare("R10 back-to-back recovery");
    // R4 drop cases
    send_pkt(8, 5, 32'h6, 1'b1, 1'b1, 1'b1);
    compare("R4 two missing");
    send_pkt(9, 3, 32'h2, 1'b0, 1'b0, 1'b1);
    compare("R4 one missing no parity");
    send_pkt(10, 0, 0, 1'b1, 1'b0, 1'b1);
    compare("R4 zero count");
    send_pkt(11, 9, 0, 1'b1, 1'b0, 1'b1);
    compare("R4 count above MAXC");

    // R6 timeout timing, ready held high
    rdy_rand = 1'b0;
    send_pkt(12, 2, 0, 1'b1, 1'b0, 1'b0);
    repeat (TMO + 1) @(negedge clk);
    check("R6 not yet valid", 66'(out_valid), 66'(0));
    @(negedge clk);
    check("R6 valid on time", 66'(out_valid), 66'(1));
    repeat (100) @(negedge clk);
    compare("R6 timeout packet");

    // R5: newer identifier closes the open packet; its header waits
    send_pkt(20, 2, 0, 1'b1, 1'b0, 1'b0);
    in_valid = 1'b1; in_tag = 2'b11; in_data = hword(21, 3, 0, 1'b0);
    #1;
    check("R5 newer header refused", 66'(in_ready), 66'(0));
    send_pkt(21, 3, 32'h4, 1'b1, 1'b0, 1'b1);
    compare("R5 close by newer packet");

    // R1/R11 random traffic
    rdy_rand = 1'b1;
    for (int p = 0; p < 24; p++) begin
      int cnt = 1 + int'($urandom % MAXC);
      int sel = int'($urandom % 4);
      int om = 0;
      int a = int'($urandom % cnt);
      int b = int'($urandom % cnt);
      if (sel == 1) om = 1 << a;
      if (sel == 2) om = (1 << a) | (1 << ((a + 1 + (b % (cnt > 1 ? cnt - 1 : 1))) % cnt));
      send_pkt(30 + p, cnt, om, ($urandom % 4) != 0, 1'b1, 1'b1);
      compare("R1/R11 random packet");
    end
    check("R8 no intake while emitting", 66'(viol), 66'(0));
    report();
    $finish;
  end
endmodule